// File: doc/BRIEF.md
# Clock-Gated Up/Down Toggle Counter

This block is a synchronous binary counter of parameterised width. It is built from a chain of toggle stages, and each stage has its own gated clock. A stage receives a clock edge only when its bit has to flip. Stages that hold their value see no edge at all, so the activity of the clock tree follows the count sequence rather than the master clock.

One toggle condition per stage serves both directions. The term for counting up requires every lower bit to be 1. The term for counting down requires every lower bit to be 0. The direction input picks the term, and the two are ORed into a single enable. That enable passes through a latch-and-AND gating cell whose latch is open while the master clock is low, so the gated clock cannot glitch.

A per-stage activity bus exposes the enables that the gating cells sample. It can be used to observe or estimate the switching load. Typical uses are clock division and the digital back end of a data converter.

Top module: `gcnt_updown`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `count` becomes 0 whatever `cnt_en` and `up_dn` are, and every bit of `stage_act` reads 1, so every stage is clocked into reset.
- R2: With `cnt_en`=1 and `up_dn`=1 at a rising edge, `count` becomes the previous value plus 1, modulo 2^WIDTH.
- R3: With `cnt_en`=1 and `up_dn`=0 at a rising edge, `count` becomes the previous value minus 1, modulo 2^WIDTH.
- R4: With `cnt_en`=0 (and `rst` low), `count` keeps its value and `stage_act` is all zeros, so no stage receives a clock edge.
- R5: Counting up, bit i of `stage_act` is 1 exactly when all bits of `count` below i are 1; bit 0 equals `cnt_en`; `stage_act` then equals the XOR of the present and the next count.
- R6: Counting down, bit i of `stage_act` is 1 exactly when all bits of `count` below i are 0; bit 0 equals `cnt_en`; `stage_act` then equals the XOR of the present and the next count.
- R7: Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R8: A change of `up_dn` between two enabled edges takes effect on the very next edge, with no count lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every stage clock is derived from it |
| rst | input | 1 | Synchronous reset, active high |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en | input | 1 | Count enable; 0 gates off every stage |
| count | output | WIDTH | Present counter value |
| stage_act | output | WIDTH | Per-stage gating enable: 1 means the stage is clocked at the next edge |

## Verification
The bench builds the counter with WIDTH=8. At that width a full turn of 256 states fits in a few hundred cycles, so both wrap points are reached from long up and down runs. The same runs visit every prefix pattern of the activity bus, up to the case where all eight stages toggle at once. Alternating and pseudo-random direction and enable patterns then show that a direction change costs no count. A reset applied in the middle of a run, with the enable held high, shows that reset wins over counting.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    // Count direction as seen on the up_dn pin
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    // Per-stage product terms feeding the OR merge
    typedef struct packed {
        logic up_term;
        logic down_term;
    } stage_terms_t;

    // Merge the two direction terms into one stage enable
    function automatic logic merge_terms(input stage_terms_t t,
                                         input cnt_dir_e     dir);
        logic up_sel;
        logic dn_sel;
        up_sel = t.up_term   & (dir == DIR_UP);
        dn_sel = t.down_term & (dir == DIR_DOWN);
        return up_sel | dn_sel;
    endfunction

endpackage

// File: rtl/gcnt_clk_gate.sv
module gcnt_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    // Latch is open while clk is low, so en is frozen during the high phase
    logic en_lat;

    always_latch begin
        if (!clk) begin
            en_lat <= en;
        end
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/gcnt_tstage.sv
module gcnt_tstage (
    input  logic gclk,
    input  logic rst,
    output logic q
);
    // A stage only sees an edge when it must change, so it always inverts
    always_ff @(posedge gclk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/gcnt_toggle_terms.sv
module gcnt_toggle_terms
    import gcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    input  cnt_dir_e         dir,
    input  logic             cnt_en,
    input  logic             rst,
    output logic [WIDTH-1:0] tgl
);
    localparam int CHAIN = WIDTH + 1;

    // Prefix chains: all lower bits one / all lower bits zero
    logic [CHAIN-1:0] ones_chain;
    logic [CHAIN-1:0] zeros_chain;
    stage_terms_t     terms [WIDTH];

    assign ones_chain[0]  = 1'b1;
    assign zeros_chain[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign ones_chain[i+1]  = ones_chain[i]  & q[i];
        assign zeros_chain[i+1] = zeros_chain[i] & ~q[i];

        assign terms[i].up_term   = ones_chain[i];
        assign terms[i].down_term = zeros_chain[i];

        // Reset forces the stage clock so the synchronous clear reaches it
        assign tgl[i] = rst | (cnt_en & merge_terms(terms[i], dir));
    end

    // Top of the chains only matters for a carry-out, which this block omits
    logic unused_top;
    assign unused_top = ones_chain[WIDTH] ^ zeros_chain[WIDTH];
endmodule

// File: rtl/gcnt_updown.sv
module gcnt_updown
    import gcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_dn,
    input  logic             cnt_en,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] stage_act
);
    cnt_dir_e         dir;
    logic [WIDTH-1:0] tgl;
    logic [WIDTH-1:0] gclk;
    logic [WIDTH-1:0] q;

    assign dir = cnt_dir_e'(up_dn);

    gcnt_toggle_terms #(.WIDTH(WIDTH)) u_terms (
        .q      (q),
        .dir    (dir),
        .cnt_en (cnt_en),
        .rst    (rst),
        .tgl    (tgl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        gcnt_clk_gate u_gate (
            .clk  (clk),
            .en   (tgl[i]),
            .gclk (gclk[i])
        );

        gcnt_tstage u_stage (
            .gclk (gclk[i]),
            .rst  (rst),
            .q    (q[i])
        );
    end

    assign count     = q;
    assign stage_act = tgl;
endmodule

// File: rtl/gcnt_updown_chk.sv
module gcnt_updown_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             up_dn,
    input logic             cnt_en,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] stage_act
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cnt_en) && $past(up_dn))
            |-> (count == WIDTH'($past(count) + 1'b1)));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cnt_en) && !$past(up_dn))
            |-> (count == WIDTH'($past(count) - 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cnt_en)) |-> $stable(count));

    // R5
    act_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((count ^ $past(count)) == $past(stage_act)));

    // R6
    act_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        stage_act[0] == cnt_en);
endmodule

bind gcnt_updown gcnt_updown_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .up_dn     (up_dn),
    .cnt_en    (cnt_en),
    .count     (count),
    .stage_act (stage_act)
);

// File: tb/gcnt_updown_bench.sv
module gcnt_updown_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk    = 1'b0;
    logic         rst    = 1'b1;
    logic         up_dn  = 1'b1;
    logic         cnt_en = 1'b0;
    logic [W-1:0] count;
    logic [W-1:0] stage_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcnt_updown #(.WIDTH(W)) u_gcnt_updown (
        .clk       (clk),
        .rst       (rst),
        .up_dn     (up_dn),
        .cnt_en    (cnt_en),
        .count     (count),
        .stage_act (stage_act)
    );

    int           n_checks = 0;
    int           n_fails  = 0;
    bit           done     = 0;
    logic [W-1:0] model    = '0;
    bit           prev_up  = 1'b1;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one enabled or idle clock, expected count pushed to the scoreboard
    task automatic step(input bit en, input bit up);
        logic [W-1:0] nxt;
        string        tag;
        @(negedge clk);
        cnt_en = en;
        up_dn  = up;
        if (!en)      nxt = model;
        else if (up)  nxt = W'(model + 1);
        else          nxt = W'(model - 1);
        if (!en)                                    tag = "R4";
        else if (up && model == {W{1'b1}})          tag = "R7";
        else if (!up && model == '0)                tag = "R7";
        else if (up != prev_up)                     tag = "R8";
        else if (up)                                tag = "R2";
        else                                        tag = "R3";
        #1;
        // R5 / R6: activity equals the bits about to flip; R4: none when idle
        check(!en ? "R4" : (up ? "R5" : "R6"), "stage_act", stage_act, model ^ nxt);
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        model = nxt;
        if (en) prev_up = up;
    endtask

    // Monitor: compare the count a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), "count", count, exp_q.pop_front());
            end
        end
    end

    // R1: reset with the enable held high still clears every stage
    task automatic apply_reset();
        @(negedge clk);
        rst    = 1'b1;
        cnt_en = 1'b1;
        up_dn  = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1", "count", count, '0);
        check("R1", "stage_act", stage_act, {W{1'b1}});
        @(negedge clk);
        #1;
        check("R1", "count", count, '0);
        rst    = 1'b0;
        cnt_en = 1'b0;
        model  = '0;
        prev_up = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        apply_reset();

        // R2, R7: up past the wrap
        for (int i = 0; i < 260; i++) step(1'b1, 1'b1);
        // R4: idle
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        // R3, R7: down past the wrap
        for (int i = 0; i < 270; i++) step(1'b1, 1'b0);
        // R8: alternate direction every edge, then every second edge
        for (int i = 0; i < 20; i++) step(1'b1, i[0]);
        for (int i = 0; i < 20; i++) step(1'b1, i[1]);
        // Mixed pseudo-random enable and direction
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[1]);
        end
        step(1'b0, 1'b1);
        // R1: reset in the middle of a run
        for (int i = 0; i < 37; i++) step(1'b1, 1'b1);
        @(posedge clk);
        #(CLK_PERIOD/2);
        apply_reset();
        // R3, R7: count down from zero right after reset
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule